// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a simple synchronous host port and an external asynchronous static RAM of 32K words by 16 bits. The host issues one-cycle request strobes. Each request carries an address, write data, a two-bit lane mask and a read/write select. The controller turns each request into a correctly timed cycle on the RAM pins. These are an address bus, active-low chip, output and write enables, one active-low enable per byte lane, and a shared bidirectional data bus. When the cycle completes, the controller returns a one-cycle acknowledge, plus the captured data for a read.

The clock period is a parameter given in nanoseconds. Every phase length is derived from the RAM's nanosecond limits by rounding up to whole clocks, with a floor of one clock. A write ends by raising the byte enables while chip and write enable stay low for one more cycle. During that cycle the data is still driven, so the hold time is covered. A write request that arrives in that cycle goes straight into the next word's window, which gives lane-pulsed back-to-back writes. A read that follows a write is preceded by one quiet turnaround cycle.

A new request may be presented in the acknowledge cycle, or in any later cycle while the controller is idle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, chip, output and write enables and both byte enables are high and the acknowledge is low.
- R2: A write with a nonzero mask holds chip and write enable low, output enable high, the address stable and `sram_be_n` equal to the inverted mask for `WR_CYC` cycles. Mask bit 0 selects data bits 7:0 and mask bit 1 selects bits 15:8. `WR_CYC` is the largest of ceil(12/T), ceil(9/T) and ceil(6/T), with T the clock period in ns and a minimum of 1.
- R3: After its window, a write raises both byte enables while chip and write enable stay low and the data is still driven, and it acknowledges in that cycle. The acknowledge comes `WR_CYC`+1 cycles after the request.
- R4: A write request presented in a write's acknowledge cycle starts the next word's window at once, without chip or write enable rising in between.
- R5: A read with a nonzero mask holds chip and output enable low, write enable high and `sram_be_n` equal to the inverted mask for `RD_CYC` cycles. `RD_CYC` is the larger of ceil(12/T) for cycle time and ceil(12/T) for address access, with a minimum of 1.
- R6: A read captures the requested lanes at the end of its access count and returns zero in unrequested lanes. It acknowledges `RD_CYC`+1 cycles after the request.
- R7: A read that follows a write is preceded by exactly one cycle with all strobes high, which adds one cycle to its latency.
- R8: A request with mask 0 is acknowledged one cycle later with no strobe activity, and the memory contents are unchanged.
- R9: When no request arrives in an acknowledge cycle, the next cycle has all strobes high and the data bus released.
- R10: The controller drives the data bus only while chip and write enable are both low.
- R11: Output enable and write enable are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle request strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_mask | input | DATA_W/8 | Lane mask, bit i selects bits 8i+7:8i |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read data, valid with the acknowledge |
| sram_addr | output | ADDR_W | RAM address |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_be_n | output | DATA_W/8 | RAM byte-lane enables, active low |
| sram_dq | inout | DATA_W | RAM data bus |

## Verification
The bench runs seeded random sequences that mix reads and writes over a small set of addresses, including the top address. Each lane mask appears, and the idle gap between requests is zero, one or two cycles. A zero gap after a write exercises the lane-pulsed back-to-back path, while a longer gap exercises the return to idle, so the two paths are told apart. Reads that directly follow writes are separated from reads after reads by their latency, which shows whether the turnaround cycle is present. Single-lane writes, with the other lane read back afterwards, show that lane gating is correct in both directions. Zero-mask requests are checked for their one-cycle acknowledge and an unchanged memory. The RAM model tags each word with its full address, so a wrong address bit shows up as corrupted read data.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int CLK_NS = 20,
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  parameter int T_RC_NS = 12,
  parameter int T_AA_NS = 12,
  parameter int T_WC_NS = 12,
  parameter int T_WP_NS = 9,
  parameter int T_DS_NS = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_req,
  input  logic                  host_wr,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [DATA_W-1:0]     host_wdata,
  input  logic [DATA_W/8-1:0]   host_mask,
  output logic                  host_ack,
  output logic [DATA_W-1:0]     host_rdata,
  output logic [ADDR_W-1:0]     sram_addr,
  output logic                  sram_ce_n,
  output logic                  sram_oe_n,
  output logic                  sram_we_n,
  output logic [DATA_W/8-1:0]   sram_be_n,
  inout  wire  [DATA_W-1:0]     sram_dq
);

  localparam int LANES = DATA_W / 8;

  function automatic int clocks(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = imax(clocks(T_RC_NS), clocks(T_AA_NS));
  localparam int WR_CYC = imax(clocks(T_WC_NS), imax(clocks(T_WP_NS), clocks(T_DS_NS)));
  localparam int CNT_W  = $clog2(imax(RD_CYC, WR_CYC) + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_RD, S_WR, S_WACK} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LANES-1:0]   mask_q;
  logic               wr_last;
  logic               dq_drive;

  assign sram_addr = addr_q;
  assign sram_ce_n = !(state == S_RD || state == S_WR || state == S_WACK);
  assign sram_oe_n = (state != S_RD);
  assign sram_we_n = !(state == S_WR || state == S_WACK);
  assign sram_be_n = (state == S_RD || state == S_WR) ? ~mask_q : '1;
  assign dq_drive  = (state == S_WR || state == S_WACK);
  assign sram_dq   = dq_drive ? wdata_q : 'z;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cnt        <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      mask_q     <= '0;
      wr_last    <= 1'b0;
      host_ack   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack <= 1'b0;
      unique case (state)
        S_IDLE, S_WACK: begin
          if (host_req) begin
            if (host_mask == '0) begin
              host_ack <= 1'b1;
              state    <= S_IDLE;
            end else begin
              addr_q  <= host_addr;
              wdata_q <= host_wdata;
              mask_q  <= host_mask;
              if (host_wr) begin
                state   <= S_WR;
                cnt     <= WR_LAST;
                wr_last <= 1'b1;
              end else if (wr_last) begin
                state <= S_TURN;
              end else begin
                state <= S_RD;
                cnt   <= RD_LAST;
              end
            end
          end else begin
            state <= S_IDLE;
          end
        end
        S_TURN: begin
          state   <= S_RD;
          cnt     <= RD_LAST;
          wr_last <= 1'b0;
        end
        S_RD: begin
          if (cnt == '0) begin
            for (int i = 0; i < LANES; i++)
              host_rdata[i*8 +: 8] <= mask_q[i] ? sram_dq[i*8 +: 8] : 8'h00;
            host_ack <= 1'b1;
            state    <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WR: begin
          if (cnt == '0) begin
            host_ack <= 1'b1;
            state    <= S_WACK;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module sram_lane_ctrl_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             ce_n,
  input logic             oe_n,
  input logic             we_n,
  input logic [LANES-1:0] be_n,
  input logic             drive,
  input logic             ack
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (ce_n && oe_n && we_n && (&be_n) && !ack));

  p_drive_window_r10: assert property (@(posedge clk) disable iff (rst)
    drive |-> (!ce_n && !we_n));

  p_oe_we_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));

  p_turnaround_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n) |-> $past(we_n));

  p_lane_end_ack_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(&be_n) && !we_n) |-> ack);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .ce_n(sram_ce_n), .oe_n(sram_oe_n), .we_n(sram_we_n),
  .be_n(sram_be_n), .drive(dq_drive), .ack(host_ack)
);

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
  localparam int TB_CLK_NS = 4;
  localparam int AW = 15;
  localparam int DW = 16;

  function automatic int clocks(input int ns);
    int c;
    c = (ns + TB_CLK_NS - 1) / TB_CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int RD_C = (clocks(12) > clocks(12)) ? clocks(12) : clocks(12);
  localparam int WR_C = (clocks(12) > clocks(9)) ? ((clocks(12) > clocks(6)) ? clocks(12) : clocks(6))
                                                 : ((clocks(9) > clocks(6)) ? clocks(9) : clocks(6));

  logic clk = 0, rst = 1;
  logic host_req = 0, host_wr = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [1:0] host_mask = '0;
  logic host_ack;
  logic [DW-1:0] host_rdata;
  logic [AW-1:0] sram_addr;
  logic sram_ce_n, sram_oe_n, sram_we_n;
  logic [1:0] sram_be_n;
  wire  [DW-1:0] sram_dq;

  always #10 clk = ~clk;

  sram_lane_ctrl #(.CLK_NS(TB_CLK_NS)) dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_mask(host_mask), .host_ack(host_ack), .host_rdata(host_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_be_n(sram_be_n), .sram_dq(sram_dq)
  );

  // RAM model: 64 words, each tagged with the upper address bits
  logic [15:0] mmem [64];
  logic [8:0]  mtag [64];
  logic [15:0] mdat;
  logic [5:0]  ma;
  assign ma = sram_addr[5:0];
  always_comb mdat = (mtag[ma] == sram_addr[14:6]) ? mmem[ma] : 16'hDEAD;
  assign sram_dq[7:0]  = (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_be_n[0]) ? mdat[7:0]  : 8'bz;
  assign sram_dq[15:8] = (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_be_n[1]) ? mdat[15:8] : 8'bz;
  always @(posedge clk) begin
    if (!sram_ce_n && !sram_we_n) begin
      if (!sram_be_n[0]) begin mmem[ma][7:0]  = sram_dq[7:0];  mtag[ma] = sram_addr[14:6]; end
      if (!sram_be_n[1]) begin mmem[ma][15:8] = sram_dq[15:8]; mtag[ma] = sram_addr[14:6]; end
    end
  end

  int vectors = 0, miscompares = 0;
  logic [15:0] ref_mem [64];
  bit last_wr = 0;
  bit done = 0;

  function automatic logic [AW-1:0] addr_of(input int idx);
    logic [8:0] hi;
    hi = (idx == 63) ? 9'h1FF : 9'(idx * 7);
    return {hi, 6'(idx)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input bit wr, input int idx, input logic [15:0] d, input logic [1:0] m);
    int n, exp_lat;
    bit turn;
    logic [15:0] expd;
    turn = !wr && (m != 0) && last_wr;
    exp_lat = (m == 0) ? 1 : wr ? WR_C + 1 : RD_C + 1 + (turn ? 1 : 0);
    host_req = 1; host_wr = wr; host_addr = addr_of(idx); host_wdata = d; host_mask = m;
    @(negedge clk);
    host_req = 0; host_wdata = ~d; host_addr = ~addr_of(idx);
    n = 1;
    if (m == 0) begin
      check(host_ack && sram_ce_n && sram_we_n && sram_oe_n, "R8 zero-mask quiet ack",
            {sram_ce_n, sram_we_n, host_ack}, 3'b111);
    end else if (wr) begin
      check(!sram_ce_n && !sram_we_n && sram_oe_n && sram_be_n == ~m && sram_addr == addr_of(idx),
            "R2 write strobes", {sram_ce_n, sram_we_n, sram_oe_n, sram_be_n, 1'b0, sram_addr},
            {3'b001, ~m, 1'b0, addr_of(idx)});
    end else begin
      if (turn) begin
        check(sram_ce_n && sram_oe_n && sram_we_n && sram_be_n == 2'b11, "R7 turnaround quiet",
              {sram_ce_n, sram_oe_n, sram_we_n, sram_be_n}, 5'b11111);
        @(negedge clk); n++;
      end
      check(!sram_ce_n && !sram_oe_n && sram_we_n && sram_be_n == ~m && sram_addr == addr_of(idx),
            "R5 read strobes", {sram_ce_n, sram_oe_n, sram_we_n, sram_be_n, 1'b0, sram_addr},
            {3'b001, ~m, 1'b0, addr_of(idx)});
    end
    while (!host_ack && n < 40) begin @(negedge clk); n++; end
    check(n == exp_lat, wr ? "R3 write latency" : (turn ? "R7 read latency" : "R6 read latency"), n, exp_lat);
    if (m != 0) begin
      if (wr) begin
        check(sram_be_n == 2'b11 && !sram_ce_n && !sram_we_n && sram_dq == d, "R3 lane-ended hold",
              {sram_be_n, sram_ce_n, sram_we_n, sram_dq}, {4'b1100, d});
        if (m[0]) ref_mem[idx][7:0]  = d[7:0];
        if (m[1]) ref_mem[idx][15:8] = d[15:8];
        last_wr = 1;
      end else begin
        expd = {m[1] ? ref_mem[idx][15:8] : 8'h00, m[0] ? ref_mem[idx][7:0] : 8'h00};
        check(host_rdata == expd, "R6 read data", host_rdata, expd);
        last_wr = 0;
      end
    end
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(sram_ce_n && sram_oe_n && sram_we_n && sram_be_n == 2'b11, "R9 idle strobes",
            {sram_ce_n, sram_oe_n, sram_we_n, sram_be_n}, 5'b11111);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog act=1 exp=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mmem[i] = 16'h0; mtag[i] = addr_of(i)[14:6]; ref_mem[i] = 16'h0;
    end
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(sram_ce_n && sram_oe_n && sram_we_n && sram_be_n == 2'b11 && !host_ack, "R1 reset state",
          {sram_ce_n, sram_oe_n, sram_we_n, sram_be_n, host_ack}, 6'b111110);
    rst = 0;
    @(negedge clk);
    check(sram_ce_n && sram_oe_n && sram_we_n && !host_ack, "R1 after reset",
          {sram_ce_n, sram_oe_n, sram_we_n, host_ack}, 4'b1110);

    // directed corners
    op(1, 5, 16'hA1B2, 2'b11);
    op(1, 6, 16'hC3D4, 2'b11);          // R4 back-to-back from ack cycle
    op(1, 63, 16'h7E81, 2'b11);         // top address
    op(0, 5, 16'h0, 2'b11);             // R7 read right after write
    op(0, 6, 16'h0, 2'b11);             // read after read, no turnaround
    idle(2);
    op(1, 5, 16'h55EE, 2'b01);          // lower lane only
    op(1, 6, 16'h99FF, 2'b10);          // upper lane only
    idle(1);
    op(0, 5, 16'h0, 2'b11);
    op(0, 6, 16'h0, 2'b01);             // R6 unrequested lane reads zero
    op(1, 63, 16'h1234, 2'b00);         // R8 zero-mask write
    op(0, 63, 16'h0, 2'b00);            // R8 zero-mask read
    op(0, 63, 16'h0, 2'b11);            // R8 memory unchanged
    idle(1);

    // constrained random
    for (int k = 0; k < 300; k++) begin
      int idx, gap;
      idx = ($urandom % 5 == 0) ? 63 : int'($urandom % 8);
      op(1'($urandom % 2), idx, 16'($urandom), 2'($urandom % 4));
      gap = $urandom % 3;
      if (gap != 0) idle(gap);
    end
    op(0, 63, 16'h0, 2'b11);
    idle(1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule